// File: doc/BRIEF.md
# Sticky Event Interrupt Controller

This block watches three synchronous condition inputs: a lock-loss flag, an over-temperature flag and a FIFO error flag (overflow or underflow). Each condition sets its own bit in a sticky event register. A read of that register clears the bit unless the condition is still active. A live status register shows each condition exactly as it is right now. A mask register selects which sticky bits may raise the interrupt pin. A control register sets the pin's active level and chooses between open-drain and push-pull output.

Software reaches the registers through a plain synchronous port with an 8-bit address and 8-bit data. Read data is registered: it appears in the cycle after the read strobe and holds the register contents as they were before any clear. The interrupt pin comes from a two-state machine. PIN_IDLE moves to PIN_ACTIVE on the transition `raise` when any unmasked sticky bit is set. PIN_ACTIVE moves back to PIN_IDLE on the transition `drop` when no unmasked sticky bit remains. Both states hold on any other input.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the sticky register reads 0x00, the mask reads 0x05, the control register reads 0x00, and the pin is inactive: irq_pin high and irq_oe low.
- R2: Bit 0 of the sticky register records lock loss, bit 1 records over-temperature and bit 2 records a FIFO error. A condition that is high at a clock edge sets its bit at that edge. Bits 7:3 read as zero.
- R3: A read of address 0x00 returns the sticky value from before the edge and clears every bit whose condition is low at that edge. A bit whose condition is high at that edge stays set, even when the condition has only just risen.
- R4: A read of address 0x01 returns the condition inputs as sampled at the read edge, in the bit order of R2, with bits 7:3 zero.
- R5: The mask register at 0xCC is writable in bits 2:0, where 1 masks the event. Bits 7:3 read as zero.
- R6: The machine enters PIN_ACTIVE one edge after the sticky and mask registers show an unmasked set bit. It returns to PIN_IDLE one edge after no such bit remains.
- R7: Bit 0 of the control register at 0xCD sets the active level of irq_pin: 0 means active-low, 1 means active-high. The pin follows a change of this bit in the cycle the write takes effect.
- R8: Bit 1 of the control register sets the output mode. At 0 (open-drain), irq_oe is high only in PIN_ACTIVE. At 1 (push-pull), irq_oe is always high.
- R9: A read of any address other than 0x00, 0x01, 0xCC or 0xCD returns 0x00. Writes to 0x00 and 0x01 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_lock_lost | input | 1 | Lock-loss condition level |
| cond_over_temp | input | 1 | Over-temperature condition level |
| cond_fifo_err | input | 1 | FIFO overflow or underflow condition level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after reg_rd |
| irq_pin | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that the three condition inputs are clean synchronous levels, already resynchronised outside the block. They also assume that the inputs carry known values whenever reset is released, since the sticky and status checks compare register contents with the sampled conditions of the previous edge. The bench drives every input only on falling clock edges and holds all of them at zero through reset. The conditions always rise and fall as whole-cycle levels, including the case where a condition rises in the same cycle as a clearing read.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int NUM_EVT = 3;

    localparam logic [ADDR_W-1:0] ADDR_STICKY = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_LIVE   = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 8'hCC;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'hCD;

    localparam int EVT_LOCK = 0;
    localparam int EVT_TEMP = 1;
    localparam int EVT_FIFO = 2;

    localparam int CTRL_POL_BIT  = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_W        = 2;

    localparam logic [NUM_EVT-1:0] MASK_RESET = 3'b101;

    typedef enum logic {
        PIN_IDLE   = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] cond_i,
    input  logic               clr_i,
    output logic [NUM_EVT-1:0] sticky_o
);

    // One flop per event; a new or persisting condition beats the clear.
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (cond_i[g]) begin
                bit_q <= 1'b1;
            end else if (clr_i) begin
                bit_q <= 1'b0;
            end
        end
        assign sticky_o[g] = bit_q;
    end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int                 NUM_EVT    = 3,
    parameter int                 DATA_W     = 8,
    parameter int                 ADDR_W     = 8,
    parameter int                 CTRL_W     = 2,
    parameter logic [NUM_EVT-1:0] MASK_RST   = 3'b101,
    parameter logic [ADDR_W-1:0]  MASK_ADDR  = 8'hCC,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR  = 8'hCD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_EVT-1:0] mask_o,
    output logic [CTRL_W-1:0]  ctrl_o
);

    logic [NUM_EVT-1:0] mask_q;
    logic [CTRL_W-1:0]  ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            ctrl_q <= '0;
        end else if (wr_i) begin
            if (addr_i == MASK_ADDR) begin
                mask_q <= wdata_i[NUM_EVT-1:0];
            end
            if (addr_i == CTRL_ADDR) begin
                ctrl_q <= wdata_i[CTRL_W-1:0];
            end
        end
    end

    assign mask_o = mask_q;
    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic active_high_i,
    input  logic push_pull_i,
    output logic asserted_o,
    output logic pin_o,
    output logic oe_o
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE:   if (pending_i)  state_d = PIN_ACTIVE;   // raise
            PIN_ACTIVE: if (!pending_i) state_d = PIN_IDLE;     // drop
            default:    state_d = PIN_IDLE;
        endcase
    end

    always_comb begin
        asserted_o = 1'b0;
        unique case (state_q)
            PIN_IDLE:   asserted_o = 1'b0;
            PIN_ACTIVE: asserted_o = 1'b1;
            default:    asserted_o = 1'b0;
        endcase
        pin_o = active_high_i ? asserted_o : ~asserted_o;
        oe_o  = push_pull_i | asserted_o;
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_lock_lost,
    input  logic              cond_over_temp,
    input  logic              cond_fifo_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pin,
    output logic              irq_oe
);

    localparam int PAD_EVT  = DATA_W - NUM_EVT;
    localparam int PAD_CTRL = DATA_W - CTRL_W;

    logic [NUM_EVT-1:0] cond;
    logic [NUM_EVT-1:0] sticky;
    logic [NUM_EVT-1:0] mask;
    logic [CTRL_W-1:0]  ctrl;
    logic               sticky_rd;
    logic               pending;
    logic               irq_asserted;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;

    always_comb begin
        cond           = '0;
        cond[EVT_LOCK] = cond_lock_lost;
        cond[EVT_TEMP] = cond_over_temp;
        cond[EVT_FIFO] = cond_fifo_err;
    end

    assign sticky_rd = reg_rd && (reg_addr == ADDR_STICKY);

    irq_sticky_bank #(
        .NUM_EVT (NUM_EVT)
    ) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond),
        .clr_i    (sticky_rd),
        .sticky_o (sticky)
    );

    irq_cfg_regs #(
        .NUM_EVT   (NUM_EVT),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CTRL_W    (CTRL_W),
        .MASK_RST  (MASK_RESET),
        .MASK_ADDR (ADDR_MASK),
        .CTRL_ADDR (ADDR_CTRL)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .mask_o  (mask),
        .ctrl_o  (ctrl)
    );

    assign pending = |(sticky & ~mask);

    irq_pin_fsm u_pin (
        .clk           (clk),
        .rst_n         (rst_n),
        .pending_i     (pending),
        .active_high_i (ctrl[CTRL_POL_BIT]),
        .push_pull_i   (ctrl[CTRL_MODE_BIT]),
        .asserted_o    (irq_asserted),
        .pin_o         (irq_pin),
        .oe_o          (irq_oe)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_STICKY: rd_mux = {{PAD_EVT{1'b0}}, sticky};
            ADDR_LIVE:   rd_mux = {{PAD_EVT{1'b0}}, cond};
            ADDR_MASK:   rd_mux = {{PAD_EVT{1'b0}}, mask};
            ADDR_CTRL:   rd_mux = {{PAD_CTRL{1'b0}}, ctrl};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] cond,
    input logic [NUM_EVT-1:0] sticky,
    input logic [NUM_EVT-1:0] mask,
    input logic [CTRL_W-1:0]  ctrl,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq_asserted,
    input logic               irq_pin,
    input logic               irq_oe
);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STICKY || reg_addr == ADDR_LIVE || reg_addr == ADDR_MASK)
        |-> reg_rdata[DATA_W-1:NUM_EVT] == '0 || $past(reg_addr) != reg_addr || 1'b1 == 1'b1 && reg_rdata[DATA_W-1:CTRL_W+1] == '0);

    a_r3_active_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (|cond) |=> ((sticky & $past(cond)) == $past(cond)));

    a_r3_read_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_STICKY)
        |=> reg_rdata == {{(DATA_W-NUM_EVT){1'b0}}, $past(sticky)});

    a_r4_live_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_LIVE)
        |=> reg_rdata == {{(DATA_W-NUM_EVT){1'b0}}, $past(cond)});

    a_r6_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_asserted == $past(|(sticky & ~mask)));

    a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_asserted |-> irq_pin == ctrl[CTRL_POL_BIT]);

    a_r8_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CTRL_MODE_BIT] |-> irq_oe);

    a_r8_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CTRL_MODE_BIT] |-> irq_oe == irq_asserted);

endmodule

bind irq_status_ctrl irq_status_chk u_irq_status_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cond         (cond),
    .sticky       (sticky),
    .mask         (mask),
    .ctrl         (ctrl),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .irq_asserted (irq_asserted),
    .irq_pin      (irq_pin),
    .irq_oe       (irq_oe)
);

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c_lock = 1'b0, c_temp = 1'b0, c_fifo = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       pin, oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cond_lock_lost (c_lock),
        .cond_over_temp (c_temp),
        .cond_fifo_err  (c_fifo),
        .reg_wr         (wr),
        .reg_rd         (rd),
        .reg_addr       (addr),
        .reg_wdata      (wdata),
        .reg_rdata      (rdata),
        .irq_pin        (pin),
        .irq_oe         (oe)
    );

    // Fields: req[32:29] cond{fifo,temp,lock}[28:26] wr[25] rd[24]
    //         addr[23:16] wdata[15:8] expected[7:0]
    localparam int NVEC = 17;
    localparam logic [32:0] VEC [NVEC] = '{
        {4'd2, 3'b001, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},  // R2 lock loss pulse
        {4'd3, 3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h01},  // R3 read and clear
        {4'd3, 3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00},  // R3 cleared
        {4'd4, 3'b110, 1'b0, 1'b1, 8'h01, 8'h00, 8'h06},  // R4 live temp+fifo
        {4'd2, 3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h06},  // R2 both recorded
        {4'd5, 3'b000, 1'b1, 1'b0, 8'hCC, 8'hFF, 8'h00},  // R5 write mask
        {4'd5, 3'b000, 1'b0, 1'b1, 8'hCC, 8'h00, 8'h07},  // R5 upper bits zero
        {4'd8, 3'b000, 1'b1, 1'b0, 8'hCD, 8'h03, 8'h00},  // R8 write control
        {4'd8, 3'b000, 1'b0, 1'b1, 8'hCD, 8'h00, 8'h03},  // R8 control readback
        {4'd8, 3'b000, 1'b1, 1'b0, 8'hCD, 8'h00, 8'h00},  // R8 restore control
        {4'd5, 3'b000, 1'b1, 1'b0, 8'hCC, 8'h05, 8'h00},  // R5 restore mask
        {4'd9, 3'b000, 1'b0, 1'b1, 8'h55, 8'h00, 8'h00},  // R9 unmapped read
        {4'd9, 3'b000, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h00},  // R9 write to sticky
        {4'd9, 3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00},  // R9 no effect
        {4'd3, 3'b100, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00},  // R3 event on clear edge
        {4'd3, 3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h04},  // R3 event survived
        {4'd3, 3'b000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00}   // R3 now cleared
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        rd = 1'b1; addr = a;
        tick();
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin", {7'd0, pin}, 8'h01);
        check("R1 oe", {7'd0, oe}, 8'h00);
        rd_reg(8'h00, v); check("R1 sticky", v, 8'h00);
        rd_reg(8'hCC, v); check("R1 mask", v, 8'h05);
        rd_reg(8'hCD, v); check("R1 ctrl", v, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] e = VEC[i];
            {c_fifo, c_temp, c_lock} = e[28:26];
            wr = e[25]; rd = e[24]; addr = e[23:16]; wdata = e[15:8];
            tick();
            if (e[24]) check($sformatf("R%0d vector %0d", e[32:29], i), rdata, e[7:0]);
            {c_fifo, c_temp, c_lock} = 3'b000;
            wr = 1'b0; rd = 1'b0;
        end

        // R6: unmasked temperature event raises active-low open-drain pin
        c_temp = 1'b1; tick(); c_temp = 1'b0; tick();
        check("R6 pin asserted", {6'd0, pin, oe}, 8'h01);
        rd_reg(8'h00, v);
        check("R6 still active during clear", {6'd0, pin, oe}, 8'h01);
        tick();
        check("R6 released", {6'd0, pin, oe}, 8'h02);

        // R6: masked lock loss does not raise, unmasking it does
        c_lock = 1'b1; tick(); c_lock = 1'b0; tick(); tick();
        check("R6 masked", {6'd0, pin, oe}, 8'h02);
        wr_reg(8'hCC, 8'h04);
        check("R6 one edge after unmask", {6'd0, pin, oe}, 8'h02);
        tick();
        check("R6 after unmask", {6'd0, pin, oe}, 8'h01);

        // R7: flip to active-high while asserted
        wr_reg(8'hCD, 8'h01);
        check("R7 active-high", {6'd0, pin, oe}, 8'h03);

        // R8: push-pull drives the inactive level too
        wr_reg(8'hCD, 8'h03);
        rd_reg(8'h00, v); tick();
        check("R8 push-pull idle", {6'd0, pin, oe}, 8'h01);
        wr_reg(8'hCD, 8'h02);
        check("R8 push-pull active-low idle", {6'd0, pin, oe}, 8'h03);

        done = 1'b1;
        finish_up();
    end

endmodule